// File: doc/BRIEF.md
# Trigger Item Decision Logic

This block turns a vector of trigger conditions into one accept decision per bunch crossing. It holds a menu of trigger items. Each item is a ternary pattern made of a value and a care mask, and it matches when the conditions agree with the value on every bit the mask cares about. A matched item then passes an enable bit and a divide-by-N prescaler. Last, it must get past two vetoes: an external busy line and a dead-time limiter. There are two leaky-bucket limiters, and each item's priority bit picks the one that can hold it back.

The accept output is the OR of every item that gets through in a crossing. It comes with an 8-bit type word, which is the OR of the type fields of those items. The menu is loaded through a small write-only register port. The port takes writes only while the run-enable input is low, so a half-written menu is never used for a decision. Condition width, item count and all counter widths are parameters.

Top module: `trig_item_decider`

## Requirements
- R1: An item matches a crossing when `cond_in` equals the item's value on every bit whose care bit is 1. Bits with care 0 are ignored, so an all-zero care mask matches every crossing.
- R2: An item whose enable bit is 0 never contributes to `accept` or `trig_type`.
- R3: A condition vector applied before clock edge k decides the `accept` and `trig_type` values that appear after edge k+2, which is three register stages.
- R4: `accept` is the OR of the surviving items. `trig_type` is the bitwise OR of their 8-bit type fields, and it is zero whenever `accept` is low (including after reset).
- R5: An item with prescale factor N passes its Nth, 2Nth, 3Nth, ... enabled match, counted from the start of the run. Factors 0 and 1 pass every match.
- R6: When `busy` is high at the edge that registers a decision, every item is vetoed in that crossing.
- R7: Every accept adds one token to each of the two buckets. A bucket that already holds as many tokens as its size takes no more. Bucket p vetoes the items of priority p while its level is at or above its size, so a size of 0 blocks that priority for the whole run.
- R8: A bucket with leak interval L > 0 loses one token (if it has any) every L running cycles, counted from the start of the run. With L = 0 the bucket never leaks.
- R9: Register writes are ignored while `run_en` is high. While `run_en` is low, `accept` stays low, and the prescale counters, bucket levels and leak timers are cleared.
- R10: Register map. Address MSB 0 selects an item register: bits [ADDR_W-2:2] hold the item index, and bits [1:0] pick the field (0 value, 1 care, 2 control). Control word: bit 0 enable, bit 1 priority, bits [2 +: PS_W] prescale, bits [15:8] type. Address MSB 1 with bit 1 clear selects the limiter given by bit 0: data [LVL_W-1:0] is the size, data [8 +: LEAK_W] is the leak interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High while the menu is in use; low to load it |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address (R10) |
| cfg_wdata | input | CFG_W | Register write data |
| cond_in | input | N_COND | Trigger condition vector for the current crossing |
| busy | input | 1 | External veto for all items |
| accept | output | 1 | Registered accept decision |
| trig_type | output | 8 | Type summary of the items that fired |

## Verification
The bench builds the block with 8 conditions, 4 items, a 16-bit register word, 4-bit prescale and level fields and an 8-bit leak interval. Each item gets its own type bit, so `trig_type` shows exactly which items fired. A limiter size of 2 fills within a few crossings, and a 15-token bucket still fills within 18 cycles. That keeps saturation, the size cap, the priority-selected veto and a leak period of four cycles all visible within a short window. A prescale factor of 3 is watched over twelve consecutive crossings so that the counter reload is seen repeating.

// File: rtl/tid_pkg.sv
package tid_pkg;
   localparam int TYPE_W       = 8;
   localparam int CTL_EN_BIT   = 0;
   localparam int CTL_PRI_BIT  = 1;
   localparam int CTL_PS_LSB   = 2;
   localparam int CTL_TYPE_LSB = 8;
   localparam int BKT_LEAK_LSB = 8;
   localparam int N_BKT        = 2;

   typedef enum logic [1:0] {
      SEL_VALUE = 2'd0,
      SEL_CARE  = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_NONE  = 2'd3
   } item_sel_e;
endpackage

// File: rtl/tid_match.sv
module tid_match #(
   parameter int N_COND = 32,
   parameter int N_ITEM = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [N_COND-1:0]                cond,
   input  logic [N_ITEM-1:0][N_COND-1:0]    value,
   input  logic [N_ITEM-1:0][N_COND-1:0]    care,
   output logic [N_ITEM-1:0]                match_q
);
   logic [N_ITEM-1:0] match_d;

   for (genvar i = 0; i < N_ITEM; i++) begin : g_item
      assign match_d[i] = (((cond ^ value[i]) & care[i]) == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= '0;
      else        match_q <= match_d;
   end
endmodule

// File: rtl/tid_prescale.sv
module tid_prescale #(
   parameter int PS_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            hit,
   input  logic [PS_W-1:0] factor,
   output logic            pass
);
   logic [PS_W-1:0] cnt;
   logic            at_end;

   assign at_end = (factor <= PS_W'(1)) || (cnt >= factor - PS_W'(1));
   assign pass   = hit & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (hit) cnt <= at_end ? '0 : cnt + PS_W'(1);
   end
endmodule

// File: rtl/tid_bucket.sv
module tid_bucket #(
   parameter int LVL_W  = 8,
   parameter int LEAK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [LVL_W-1:0]  size,
   input  logic [LEAK_W-1:0] leak,
   input  logic              add,
   output logic              full,
   output logic [LVL_W-1:0]  level
);
   logic [LEAK_W-1:0] timer;
   logic              tick;
   logic [LVL_W-1:0]  lvl_drain;
   logic [LVL_W-1:0]  lvl_next;

   assign tick      = (leak != '0) && (timer == leak - LEAK_W'(1));
   assign lvl_drain = (tick && level != '0) ? level - LVL_W'(1) : level;
   assign lvl_next  = (add && lvl_drain < size) ? lvl_drain + LVL_W'(1) : lvl_drain;
   assign full      = (level >= size);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer <= '0;
         level <= '0;
      end else if (clr) begin
         timer <= '0;
         level <= '0;
      end else begin
         timer <= (leak == '0 || tick) ? '0 : timer + LEAK_W'(1);
         level <= lvl_next;
      end
   end
endmodule

// File: rtl/trig_item_decider.sv
module trig_item_decider
   import tid_pkg::*;
#(
   parameter int N_COND = 32,
   parameter int N_ITEM = 16,
   parameter int CFG_W  = 32,
   parameter int PS_W   = 6,
   parameter int LVL_W  = 8,
   parameter int LEAK_W = 16,
   localparam int IDX_W  = (N_ITEM > 1) ? $clog2(N_ITEM) : 1,
   localparam int ADDR_W = IDX_W + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_en,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic [N_COND-1:0]  cond_in,
   input  logic               busy,
   output logic               accept,
   output logic [TYPE_W-1:0]  trig_type
);
   // elaboration checks on the parameter set
   if (CFG_W < N_COND) begin : g_bad_cond
      $error("CFG_W must hold a full condition vector");
   end
   if (CFG_W < CTL_TYPE_LSB + TYPE_W) begin : g_bad_ctl
      $error("CFG_W too narrow for the control word");
   end
   if (PS_W < 1 || CTL_PS_LSB + PS_W > CTL_TYPE_LSB) begin : g_bad_ps
      $error("PS_W must lie between 1 and 6");
   end
   if (LVL_W < 1 || LVL_W > BKT_LEAK_LSB) begin : g_bad_lvl
      $error("LVL_W must lie between 1 and 8");
   end
   if (CFG_W < BKT_LEAK_LSB + LEAK_W) begin : g_bad_leak
      $error("CFG_W too narrow for the leak interval");
   end

   // register port decode
   logic            wr_ok;
   logic            glob;
   logic [IDX_W-1:0] idx;
   item_sel_e       sel;

   assign wr_ok = cfg_we & ~run_en;
   assign glob  = cfg_addr[ADDR_W-1];
   assign idx   = cfg_addr[2 +: IDX_W];
   assign sel   = item_sel_e'(cfg_addr[1:0]);

   logic [N_ITEM-1:0][N_COND-1:0] value_r;
   logic [N_ITEM-1:0][N_COND-1:0] care_r;
   logic [N_ITEM-1:0]             en_r;
   logic [N_ITEM-1:0]             pri_r;
   logic [N_ITEM-1:0][PS_W-1:0]   ps_r;
   logic [N_ITEM-1:0][TYPE_W-1:0] type_r;
   logic [N_BKT-1:0][LVL_W-1:0]   bsize_r;
   logic [N_BKT-1:0][LEAK_W-1:0]  bleak_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_r <= '0;
         care_r  <= '0;
         en_r    <= '0;
         pri_r   <= '0;
         ps_r    <= '0;
         type_r  <= '0;
      end else if (wr_ok && !glob) begin
         for (int i = 0; i < N_ITEM; i++) begin
            if (idx == IDX_W'(i)) begin
               unique case (sel)
                  SEL_VALUE: value_r[i] <= cfg_wdata[N_COND-1:0];
                  SEL_CARE:  care_r[i]  <= cfg_wdata[N_COND-1:0];
                  SEL_CTRL: begin
                     en_r[i]   <= cfg_wdata[CTL_EN_BIT];
                     pri_r[i]  <= cfg_wdata[CTL_PRI_BIT];
                     ps_r[i]   <= cfg_wdata[CTL_PS_LSB +: PS_W];
                     type_r[i] <= cfg_wdata[CTL_TYPE_LSB +: TYPE_W];
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bsize_r <= '0;
         bleak_r <= '0;
      end else if (wr_ok && glob && !cfg_addr[1]) begin
         for (int b = 0; b < N_BKT; b++) begin
            if (cfg_addr[0] == b[0]) begin
               bsize_r[b] <= cfg_wdata[LVL_W-1:0];
               bleak_r[b] <= cfg_wdata[BKT_LEAK_LSB +: LEAK_W];
            end
         end
      end
   end

   // stage 1: capture conditions
   logic [N_COND-1:0] cond_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= '0;
      else        cond_q <= cond_in;
   end

   // stage 2: ternary match
   logic [N_ITEM-1:0] match_q;
   tid_match #(.N_COND(N_COND), .N_ITEM(N_ITEM)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .cond    (cond_q),
      .value   (value_r),
      .care    (care_r),
      .match_q (match_q)
   );

   // stage 3: enable, prescale, vetoes
   logic [N_ITEM-1:0]           hit;
   logic [N_ITEM-1:0]           ps_pass;
   logic [N_ITEM-1:0]           survive;
   logic [N_BKT-1:0]            bkt_full;
   logic [N_BKT-1:0][LVL_W-1:0] bkt_lvl;
   logic                        acc_d;
   logic [TYPE_W-1:0]           type_d;

   assign hit = match_q & en_r;

   for (genvar i = 0; i < N_ITEM; i++) begin : g_ps
      tid_prescale #(.PS_W(PS_W)) u_ps (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (~run_en),
         .hit    (hit[i]),
         .factor (ps_r[i]),
         .pass   (ps_pass[i])
      );
      assign survive[i] = ps_pass[i] & ~busy & ~bkt_full[pri_r[i]];
   end

   always_comb begin
      acc_d  = run_en & (|survive);
      type_d = '0;
      for (int i = 0; i < N_ITEM; i++) begin
         if (survive[i] && run_en) type_d = type_d | type_r[i];
      end
   end

   for (genvar b = 0; b < N_BKT; b++) begin : g_bkt
      tid_bucket #(.LVL_W(LVL_W), .LEAK_W(LEAK_W)) u_bkt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (~run_en),
         .size  (bsize_r[b]),
         .leak  (bleak_r[b]),
         .add   (acc_d),
         .full  (bkt_full[b]),
         .level (bkt_lvl[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accept    <= 1'b0;
         trig_type <= '0;
      end else begin
         accept    <= acc_d;
         trig_type <= type_d;
      end
   end
endmodule

// File: rtl/tid_checker.sv
module tid_checker #(
   parameter int LVL_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  run_en,
   input logic                  busy,
   input logic                  accept,
   input logic [7:0]            trig_type,
   input logic [1:0][LVL_W-1:0] bkt_lvl,
   input logic [1:0][LVL_W-1:0] bkt_size
);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !accept);

   p_busy_veto_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !accept);

   p_type_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |-> (trig_type == 8'd0));

   for (genvar b = 0; b < 2; b++) begin : g_b
      p_level_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
         run_en |-> (bkt_lvl[b] <= bkt_size[b]));

      p_level_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
         run_en |=> (int'(bkt_lvl[b]) <= int'($past(bkt_lvl[b])) + 1));

      p_level_leak_r8: assert property (@(posedge clk) disable iff (!rst_n)
         run_en |=> (int'(bkt_lvl[b]) + 1 >= int'($past(bkt_lvl[b]))));
   end
endmodule

bind trig_item_decider tid_checker #(.LVL_W(LVL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .busy      (busy),
   .accept    (accept),
   .trig_type (trig_type),
   .bkt_lvl   (bkt_lvl),
   .bkt_size  (bsize_r)
);

// File: tb/sim_trig_item_decider.sv
module sim_trig_item_decider;
   localparam int NC = 8;
   localparam int NI = 4;
   localparam int CW = 16;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [CW-1:0] cfg_wdata = '0;
   logic [NC-1:0] cond_in = '0;
   logic          busy = 1'b0;
   logic          accept;
   logic [7:0]    trig_type;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   trig_item_decider #(
      .N_COND(NC), .N_ITEM(NI), .CFG_W(CW), .PS_W(4), .LVL_W(4), .LEAK_W(8)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cond_in(cond_in),
      .busy(busy), .accept(accept), .trig_type(trig_type)
   );

   // {cond, expected type}; items: 0 = A5 exact, 1 = bit7 set, 2 = low nibble 0, 3 disabled
   localparam logic [15:0] VEC [0:7] = '{
      16'hA5_03, 16'h80_06, 16'h00_04, 16'h13_00,
      16'hF0_06, 16'h25_00, 16'h7F_00, 16'hFA_02
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
      step(1);
      cfg_we = 1'b0;
   endtask

   // R10 field layout
   task automatic set_item(input int i, input logic [7:0] v, input logic [7:0] c,
                           input bit en, input bit pri, input logic [3:0] ps,
                           input logic [7:0] ty);
      wr({1'b0, 2'(i), 2'd0}, {8'h00, v});
      wr({1'b0, 2'(i), 2'd1}, {8'h00, c});
      wr({1'b0, 2'(i), 2'd2}, {ty, 2'b00, ps, pri, en});
   endtask

   task automatic set_bkt(input int b, input logic [3:0] size, input logic [7:0] leak);
      wr({1'b1, 2'b00, 2'(b)}, {leak, 4'h0, size});
   endtask

   task automatic clear_items();
      for (int i = 0; i < NI; i++) set_item(i, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 8'h00);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R4 reset accept", accept, 0);
      chk("R4 reset type", trig_type, 0);

      // table walk: R1 R2 R4 R10
      set_item(0, 8'hA5, 8'hFF, 1'b1, 1'b0, 4'd1, 8'h01);
      set_item(1, 8'h80, 8'h80, 1'b1, 1'b1, 4'd1, 8'h02);
      set_item(2, 8'h00, 8'h0F, 1'b1, 1'b0, 4'd0, 8'h04);
      set_item(3, 8'h00, 8'h00, 1'b0, 1'b1, 4'd1, 8'h08);
      set_bkt(0, 4'd15, 8'd1);
      set_bkt(1, 4'd15, 8'd1);
      cond_in = 8'h13;
      step(3);
      run_en = 1'b1;
      step(1);
      for (int v = 0; v < 8; v++) begin
         cond_in = VEC[v][15:8];
         step(3);
         chk("R1 table accept", accept, VEC[v][7:0] != 0);
         chk("R2 R4 table type", trig_type, VEC[v][7:0]);
      end

      // R3 latency: one matching crossing
      cond_in = 8'h13; step(3);
      cond_in = 8'hA5; step(1);
      chk("R3 after one edge", accept, 0);
      cond_in = 8'h13; step(1);
      chk("R3 after two edges", accept, 0);
      step(1);
      chk("R3 after three edges", {trig_type, 7'd0, accept}, {8'h03, 7'd0, 1'b1});
      step(1);
      chk("R3 following crossing", accept, 0);

      // R6 busy veto
      cond_in = 8'hA5; busy = 1'b1;
      step(3);
      chk("R6 busy accept", accept, 0);
      chk("R6 busy type", trig_type, 0);
      step(2);
      chk("R6 busy held", accept, 0);
      busy = 1'b0;
      step(1);
      chk("R6 busy released", {trig_type, 7'd0, accept}, {8'h03, 7'd0, 1'b1});

      // R9 writes ignored while running
      wr({1'b0, 2'd0, 2'd0}, 16'h0013);
      cond_in = 8'h13; step(3);
      chk("R9 write while running ignored (13)", accept, 0);
      cond_in = 8'hA5; step(3);
      chk("R9 old value kept", trig_type, 8'h03);

      // R9 no accept while stopped, write then taken
      run_en = 1'b0;
      step(3);
      chk("R9 stopped accept", accept, 0);
      wr({1'b0, 2'd0, 2'd0}, 16'h0013);
      cond_in = 8'h13; step(3);
      run_en = 1'b1;
      step(2);
      chk("R9 write while stopped taken", {trig_type, 7'd0, accept}, {8'h01, 7'd0, 1'b1});

      // R5 prescale factor 3
      run_en = 1'b0;
      clear_items();
      set_item(0, 8'hA5, 8'hFF, 1'b1, 1'b0, 4'd3, 8'h01);
      cond_in = 8'h13; step(3);
      run_en = 1'b1; step(2);
      cond_in = 8'hA5;
      for (int j = 1; j <= 12; j++) begin
         step(1);
         chk($sformatf("R5 prescale crossing %0d", j), accept, (j == 5 || j == 8 || j == 11));
      end

      // R7 buckets with priority
      run_en = 1'b0;
      set_item(0, 8'hA5, 8'hFF, 1'b1, 1'b0, 4'd1, 8'h01);
      set_item(1, 8'hA5, 8'hFF, 1'b1, 1'b1, 4'd1, 8'h02);
      set_bkt(0, 4'd2, 8'd0);
      set_bkt(1, 4'd15, 8'd0);
      cond_in = 8'h13; step(3);
      run_en = 1'b1; step(1);
      cond_in = 8'hA5;
      for (int j = 1; j <= 18; j++) begin
         step(1);
         chk($sformatf("R7 bucket type crossing %0d", j), trig_type,
             (j < 3 || j == 18) ? 8'h00 : (j <= 4 ? 8'h03 : 8'h02));
      end

      // R7 size zero blocks priority 0
      run_en = 1'b0;
      set_bkt(0, 4'd0, 8'd0);
      set_item(1, 8'h00, 8'h00, 1'b0, 1'b0, 4'd0, 8'h00);
      step(3);
      run_en = 1'b1;
      step(4);
      chk("R7 size zero", accept, 0);

      // R8 leak every four cycles, size 1
      run_en = 1'b0;
      set_bkt(0, 4'd1, 8'd4);
      step(3);
      run_en = 1'b1;
      for (int j = 1; j <= 9; j++) begin
         step(1);
         chk($sformatf("R8 leak crossing %0d", j), accept, (j == 1 || j == 5 || j == 9));
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R3 watchdog got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule